// File: doc/BRIEF.md
# UART Receive/Transmit Automatic Flow Control

This block performs automatic hardware handshaking for a UART whose receive buffer holds 64 characters. On the receive side it compares the buffer fill count with a selectable trigger level. It raises a data-ready interrupt request when the count reaches that level. It also drives the request-to-send line with hysteresis: the line goes high (off) at a threshold above the trigger level and goes low (on) again only once the buffer has drained to a threshold below it. Negating the line does not stop reception. The receiver still accepts characters until the buffer is full.

On the transmit side the clear-to-send input passes through a two-flop synchronizer. The synchronized level then gates the transmitter so that a pause takes effect only at a character boundary. A character already on the line keeps going through its stop bit. The transmitter starts a character only while `tx_allow` is high, and it samples `tx_allow` in the cycle after its end-of-stop-bit strobe to decide on a back-to-back character.

Two independent enables select automatic operation. When automatic RTS is off, `rts_out` follows a software bit. When automatic CTS is off, the transmitter ignores CTS.

The RTS state machine has two states. In RTS_ON (`rts_out` = 0) it goes to RTS_OFF when the count is at or above the negate threshold. In RTS_OFF it returns to RTS_ON when the count is at or below the assert threshold. The CTS state machine has three states:
- TX_RUN goes to TX_PEND when CTS is high and a character is in flight, and goes to TX_HOLD when CTS is high and the line is idle or the stop bit is just ending.
- TX_PEND goes to TX_HOLD on the end-of-stop-bit strobe while CTS is still high, and goes back to TX_RUN if CTS falls first.
- TX_HOLD goes to TX_RUN when CTS falls.

Clearing an enable forces RTS_ON or TX_RUN.

Top module: `flow_guard`

## Requirements
- R1: `trig_sel` codes 0, 1, 2 and 3 select trigger levels 1, 16, 32 and 56. `rx_irq` is 1 in the cycle after a clock edge at which `rx_level` is at or above the selected level.
- R2: `rx_irq` is 0 in the cycle after a clock edge at which `rx_level` is below the selected level.
- R3: With `rts_auto_en` = 1, `rts_out` becomes 1 after the edge at which `rx_level` reaches the negate threshold. The thresholds are 16, 32, 56 and 60 for codes 0, 1, 2 and 3.
- R4: With `rts_auto_en` = 1 and `rts_out` = 1, `rts_out` becomes 0 after the edge at which `rx_level` is at or below the assert threshold. The thresholds are 1, 8, 16 and 32 for codes 0, 1, 2 and 3.
- R5: With `rts_auto_en` = 1 and `rx_level` strictly between the two thresholds, `rts_out` keeps its previous value.
- R6: After reset, `rts_out` = 0, `rx_irq` = 0 and `tx_allow` = 1.
- R7: With `rts_auto_en` = 0, `rts_out` equals `rts_manual` with no clock delay. Re-enabling the automatic mode starts from RTS_ON.
- R8: With the line idle, a rise of `cts_in` makes `tx_allow` 0 after the third rising clock edge, and not before.
- R9: A rise of `cts_in` while `tx_active` = 1 keeps `tx_allow` at 1 until the edge at which `tx_stop_done` = 1. `tx_allow` is 0 after that edge.
- R10: A fall of `cts_in` returns `tx_allow` to 1 after the third rising edge. A fall before the stop bit ends cancels the pending pause.
- R11: With `cts_auto_en` = 0, `tx_allow` = 1 whatever the value of `cts_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Receive buffer fill count, 0..64 |
| trig_sel | input | 2 | Trigger level select |
| rts_auto_en | input | 1 | Automatic RTS enable |
| cts_auto_en | input | 1 | Automatic CTS enable |
| rts_manual | input | 1 | Software RTS value used when automatic RTS is off |
| cts_in | input | 1 | Asynchronous clear-to-send from the remote end, 1 = stop |
| tx_active | input | 1 | A character is being shifted out |
| tx_stop_done | input | 1 | One-cycle strobe at the end of the stop bit |
| rts_out | output | 1 | Request-to-send, 1 = off |
| tx_allow | output | 1 | Transmitter may continue or start a character |
| rx_irq | output | 1 | Receive data-ready interrupt request |

## Verification
The receive side is driven with slow ramps from empty to full and back for each trigger code. These ramps tell the negate threshold apart from the assert threshold, and they expose any off-by-one error at both. A pseudo-random sequence of large jumps follows, with the trigger code changing along the way. It separates the hold behaviour of the hysteresis band from a simple threshold compare. The transmit side is tried three ways: CTS rising on an idle line, CTS rising mid-character with the stop strobe arriving later, and CTS rising mid-character and falling before the stop strobe. Together these tell an immediate pause, a deferred pause and a cancelled one apart. Each automatic path is also toggled against its bypass.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic {
        RTS_ON,
        RTS_OFF
    } rts_state_t;

    typedef enum logic [1:0] {
        TX_RUN,
        TX_PEND,
        TX_HOLD
    } tx_state_t;

    // Trigger level for a select code, scaled from the buffer depth.
    function automatic int trig_of(input logic [1:0] sel, input int d);
        case (sel)
            2'd0:    return 1;
            2'd1:    return d / 4;
            2'd2:    return d / 2;
            default: return d - d / 8;
        endcase
    endfunction

    // Fill level at which RTS goes off.
    function automatic int negate_of(input logic [1:0] sel, input int d);
        case (sel)
            2'd0:    return d / 4;
            2'd1:    return d / 2;
            2'd2:    return d - d / 8;
            default: return d - d / 16;
        endcase
    endfunction

    // Fill level at or below which RTS comes back on.
    function automatic int assert_of(input logic [1:0] sel, input int d);
        case (sel)
            2'd0:    return 1;
            2'd1:    return d / 8;
            2'd2:    return d / 4;
            default: return d / 2;
        endcase
    endfunction

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/fc_rx_watch.sv
module fc_rx_watch #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_level,
    input  logic [1:0]    trig_sel,
    input  logic          auto_en,
    input  logic          rts_manual,
    output logic          rts_out,
    output logic          rx_irq
);
    import fc_pkg::*;

    rts_state_t    state, nxt;
    logic [CW-1:0] trig_lv, neg_lv, asr_lv;
    logic          irq_q;

    always_comb begin
        trig_lv = CW'(trig_of(trig_sel, DEPTH));
        neg_lv  = CW'(negate_of(trig_sel, DEPTH));
        asr_lv  = CW'(assert_of(trig_sel, DEPTH));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_ON;
        else        state <= nxt;
    end

    // Interrupt request register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (rx_level >= trig_lv);
    end

    // Next state
    always_comb begin
        nxt = state;
        if (!auto_en) begin
            nxt = RTS_ON;
        end else begin
            unique case (state)
                RTS_ON:  if (rx_level >= neg_lv) nxt = RTS_OFF;
                RTS_OFF: if (rx_level <= asr_lv) nxt = RTS_ON;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rts_out = auto_en ? (state == RTS_OFF) : rts_manual;
        rx_irq  = irq_q;
    end

    a_r1_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= trig_lv) |=> rx_irq);
    a_r2_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level < trig_lv) |=> !rx_irq);
    a_r3_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && rx_level >= neg_lv) |=> (state == RTS_OFF));
    a_r4_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == RTS_OFF && rx_level <= asr_lv) |=> (state == RTS_ON));
    a_r5_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && rx_level > asr_lv && rx_level < neg_lv) |=> $stable(state));
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (state == RTS_ON));
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_s,
    input  logic tx_active,
    input  logic tx_stop_done,
    output logic tx_allow
);
    import fc_pkg::*;

    tx_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_RUN;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (!auto_en) begin
            nxt = TX_RUN;
        end else begin
            unique case (state)
                TX_RUN: begin
                    if (cts_s) begin
                        if (tx_active && !tx_stop_done) nxt = TX_PEND;
                        else                            nxt = TX_HOLD;
                    end
                end
                TX_PEND: begin
                    if (!cts_s)            nxt = TX_RUN;
                    else if (tx_stop_done) nxt = TX_HOLD;
                end
                TX_HOLD: begin
                    if (!cts_s) nxt = TX_RUN;
                end
                default: nxt = TX_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_allow = !auto_en || (state != TX_HOLD);
    end

    a_r8_idle_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && cts_s && !tx_active && state == TX_RUN) |=> (state == TX_HOLD));
    a_r9_finish_char: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_PEND && !tx_stop_done) |=> tx_allow);
    a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_s) |=> (state != TX_HOLD));
    a_r11_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> tx_allow);
endmodule

// File: rtl/flow_guard.sv
module flow_guard #(
    parameter  int DEPTH       = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_level,
    input  logic [1:0]    trig_sel,
    input  logic          rts_auto_en,
    input  logic          cts_auto_en,
    input  logic          rts_manual,
    input  logic          cts_in,
    input  logic          tx_active,
    input  logic          tx_stop_done,
    output logic          rts_out,
    output logic          tx_allow,
    output logic          rx_irq
);
    logic cts_s;

    fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cts_in),
        .dout (cts_s)
    );

    fc_rx_watch #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_level  (rx_level),
        .trig_sel  (trig_sel),
        .auto_en   (rts_auto_en),
        .rts_manual(rts_manual),
        .rts_out   (rts_out),
        .rx_irq    (rx_irq)
    );

    fc_tx_gate u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en     (cts_auto_en),
        .cts_s       (cts_s),
        .tx_active   (tx_active),
        .tx_stop_done(tx_stop_done),
        .tx_allow    (tx_allow)
    );

    // R6: the first cycle after reset release shows the idle state.
    a_r6_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_allow && !rx_irq));
endmodule

// File: tb/sim_flow_guard.sv
`timescale 1ns/1ps
module sim_flow_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_level = '0;
    logic [1:0] trig_sel = '0;
    logic       rts_auto_en = 1'b1;
    logic       cts_auto_en = 1'b1;
    logic       rts_manual = 1'b0;
    logic       cts_in = 1'b0;
    logic       tx_active = 1'b0;
    logic       tx_stop_done = 1'b0;
    logic       rts_out, tx_allow, rx_irq;

    int checks = 0;
    int fails = 0;
    bit exp_off = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flow_guard u0 (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
        .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
        .rts_manual(rts_manual), .cts_in(cts_in), .tx_active(tx_active),
        .tx_stop_done(tx_stop_done), .rts_out(rts_out), .tx_allow(tx_allow),
        .rx_irq(rx_irq)
    );

    function automatic int trig_tab(int s);
        return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
    endfunction
    function automatic int neg_tab(int s);
        return (s == 0) ? 16 : (s == 1) ? 32 : (s == 2) ? 56 : 60;
    endfunction
    function automatic int asr_tab(int s);
        return (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 16 : 32;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Apply a fill count, clock once, compare against the model.
    task automatic apply(input int cnt);
        rx_level = 7'(cnt);
        tick();
        if (exp_off) begin
            if (cnt <= asr_tab(trig_sel)) exp_off = 1'b0;
        end else if (cnt >= neg_tab(trig_sel)) begin
            exp_off = 1'b1;
        end
        chk((cnt >= trig_tab(trig_sel)) ? "R1" : "R2", rx_irq, logic'(cnt >= trig_tab(trig_sel)));
        chk(exp_off ? "R3" : "R4/R5", rts_out, exp_off);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int unsigned v;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", rts_out, 1'b0);
        chk("R6", rx_irq, 1'b0);
        chk("R6", tx_allow, 1'b1);

        // Ramp sweeps per trigger code (R1..R5)
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            apply(0);
            for (int n = 0; n <= 64; n++) apply(n);
            for (int n = 64; n >= 0; n--) apply(n);
        end

        // Pseudo-random jumps with trigger changes (R5 band hold)
        v = 32'd7;
        for (int k = 0; k < 400; k++) begin
            v = v * 32'd1103515245 + 32'd12345;
            c = int'((v >> 16) % 65);
            if (k % 25 == 0) trig_sel = 2'((v >> 8) % 4);
            apply(c);
        end

        // R7: bypass of automatic RTS
        rts_auto_en = 1'b0;
        rts_manual = 1'b1;
        #1;
        chk("R7", rts_out, 1'b1);
        rx_level = 7'd0;
        tick();
        chk("R7", rts_out, 1'b1);
        rts_manual = 1'b0;
        #1;
        chk("R7", rts_out, 1'b0);
        rx_level = 7'd64;
        tick();
        chk("R7", rts_out, 1'b0);
        trig_sel = 2'd1;
        rx_level = 7'd20;
        tick();
        rts_auto_en = 1'b1;
        exp_off = 1'b0;
        tick();
        chk("R7", rts_out, 1'b0);
        apply(20);
        rx_level = 7'd0;
        tick();
        exp_off = 1'b0;

        // R8: idle pause takes three edges
        cts_in = 1'b1;
        tick(); chk("R8", tx_allow, 1'b1);
        tick(); chk("R8", tx_allow, 1'b1);
        tick(); chk("R8", tx_allow, 1'b0);
        // R10: resume takes three edges
        cts_in = 1'b0;
        tick(); chk("R10", tx_allow, 1'b0);
        tick(); chk("R10", tx_allow, 1'b0);
        tick(); chk("R10", tx_allow, 1'b1);

        // R9: pause deferred until stop bit ends
        tx_active = 1'b1;
        tick();
        cts_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R9", tx_allow, 1'b1);
        end
        tx_stop_done = 1'b1;
        tick();
        tx_stop_done = 1'b0;
        tx_active = 1'b0;
        chk("R9", tx_allow, 1'b0);
        tick();
        chk("R9", tx_allow, 1'b0);
        cts_in = 1'b0;
        repeat (3) tick();
        chk("R10", tx_allow, 1'b1);

        // R10: pause cancelled by CTS falling before the stop bit
        tx_active = 1'b1;
        cts_in = 1'b1;
        repeat (4) tick();
        cts_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R10", tx_allow, 1'b1);
        end
        tx_stop_done = 1'b1;
        tick();
        tx_stop_done = 1'b0;
        tx_active = 1'b0;
        tick();
        chk("R10", tx_allow, 1'b1);

        // R11: CTS ignored when automatic CTS is off
        cts_auto_en = 1'b0;
        cts_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R11", tx_allow, 1'b1);
        end
        cts_auto_en = 1'b1;
        tick();
        chk("R8", tx_allow, 1'b0);
        cts_auto_en = 1'b0;
        #1;
        chk("R11", tx_allow, 1'b1);

        done = 1'b1;
        summary();
    end
endmodule